// File: doc/BRIEF.md
# Machine-Check Error Bank Logger

This block records hardware error reports in a parameterised set of error banks and decides, in a single cycle per report, how to handle each one. Each bank holds four 64-bit registers: an enable mask, a status word, a fault address and an auxiliary word. A capability word, a global enable mask and a global status word sit alongside the banks. An error source presents a report on the injection port. The report carries a bank index, a status word, a global status word, an address, an auxiliary value and an "unconditional" flag.

For each report the block picks one outcome. It can reject the report as malformed, discard it quietly, log it, mark an overflow on the entry already held, or escalate. For an uncorrected error it raises a machine-check interrupt. When the processor cannot take another check, it raises a reset request instead. Software reads and writes every register through a plain word-addressed port. The outcome pulses appear one cycle after the report.

Top module: `mc_logger`

## Requirements
- R1: After reset the capability word reads `{CTL_PRESENT at bit 8, NUM_BANKS in bits [7:0]}`. The global enable mask and every bank enable mask read all ones. The global status and all bank status, address and auxiliary words read zero.
- R2: A report is rejected in any of three cases: the capability word is zero, the bank index is not below both capability bits [7:0] and NUM_BANKS, or status bit 63 (valid) is clear. A rejected report pulses `reject_o` and changes no register.
- R3: A report is discarded with no output pulse and no register change when three things hold: status bit 55 (action required) is clear, `inj_uncond_i` is low, and global status bit 2 (check in progress) is set. With `inj_uncond_i` high, such a report is processed normally.
- R4: An uncorrected report (status bit 61) is discarded silently in either of two cases. The first is capability bit 8 set while the global enable mask is not all ones. The second is the target bank's enable mask not all ones. With capability bit 8 clear, the global mask is ignored.
- R5: An uncorrected report that is not discarded raises `reset_req_o` instead of logging when global status bit 2 is set or `mce_en_i` is low. No register changes.
- R6: An uncorrected report that is logged writes the bank address, auxiliary and status words and the global status word, and pulses `mce_irq_o` for one cycle. The stored status gains bit 62 (overflow) if the bank already held a valid entry.
- R7: A corrected report into a bank that is empty or holds a corrected entry overwrites the address, auxiliary and status words. It sets bit 62 if the bank was valid and raises no interrupt.
- R8: A corrected report into a bank holding an uncorrected entry only sets bit 62 of the held status. The held address and auxiliary words are kept.
- R9: Register map: word 0 is capability, 1 is global status and 2 is global enable. Bank b occupies words 4+4b..7+4b in the order enable mask, status, address, auxiliary. Unmapped words read zero. All mapped words are writable.
- R10: `reject_o`, `mce_irq_o` and `reset_req_o` are registered, at most one is high in a cycle, and each lasts one cycle per report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mce_en_i | input | 1 | Operating system has enabled machine-check delivery |
| inj_valid_i | input | 1 | Report present this cycle |
| inj_bank_i | input | 8 | Target bank index |
| inj_status_i | input | 64 | Report status word |
| inj_gstatus_i | input | 64 | Global status to store with an uncorrected report |
| inj_addr_i | input | 64 | Fault address |
| inj_misc_i | input | 64 | Auxiliary word |
| inj_uncond_i | input | 1 | Bypass the in-progress discard rule |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW (5) | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, combinational |
| reject_o | output | 1 | Report rejected |
| mce_irq_o | output | 1 | Machine-check interrupt |
| reset_req_o | output | 1 | Reset request on a nested check |

## Verification
Reports are sent in pairs into the same bank. This separates a first fill from an overwrite (overflow set) and from an uncorrected entry that must survive (overflow only). Uncorrected reports are sent with the action-required bit set and clear, with the in-progress bit held, and with delivery disabled. This tells a quiet discard apart from escalation to reset. The masks are cleared one at a time, with and without capability bit 8. That shows which enable governs the discard. Each rejection cause is applied on its own, and the bank is read back afterwards to confirm that nothing moved.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int DW       = 64;
  localparam int ST_VAL   = 63;
  localparam int ST_OVER  = 62;
  localparam int ST_UC    = 61;
  localparam int ST_AR    = 55;
  localparam int GS_MCIP  = 2;
  localparam int CAP_CTLP = 8;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_REJECT,
    ACT_DROP,
    ACT_RESET,
    ACT_LOG_UC,
    ACT_LOG_CE,
    ACT_MARK_OVF
  } mc_act_e;
endpackage

// File: rtl/mc_decide.sv
module mc_decide import mc_pkg::*; #(
  parameter int NUM_BANKS = 4
) (
  input  logic          valid_i,
  input  logic [7:0]    bank_i,
  input  logic [DW-1:0] status_i,
  input  logic          uncond_i,
  input  logic          os_en_i,
  input  logic [DW-1:0] cap_i,
  input  logic          gctl_ones_i,
  input  logic          mcip_i,
  input  logic          bank_ctl_ones_i,
  input  logic          bank_val_i,
  input  logic          bank_uc_i,
  output mc_act_e       act_o,
  output logic [DW-1:0] new_status_o
);
  logic in_range;

  always_comb begin
    in_range     = (bank_i < cap_i[7:0]) && (int'(bank_i) < NUM_BANKS);
    act_o        = ACT_NONE;
    new_status_o = status_i;
    if (!valid_i) begin
      act_o = ACT_NONE;
    end else if (cap_i == '0 || !in_range || !status_i[ST_VAL]) begin
      act_o = ACT_REJECT;
    end else if (!uncond_i && !status_i[ST_AR] && mcip_i) begin
      act_o = ACT_DROP;
    end else if (status_i[ST_UC]) begin
      if ((cap_i[CAP_CTLP] && !gctl_ones_i) || !bank_ctl_ones_i) begin
        act_o = ACT_DROP;
      end else if (mcip_i || !os_en_i) begin
        act_o = ACT_RESET;
      end else begin
        act_o = ACT_LOG_UC;
        if (bank_val_i) new_status_o[ST_OVER] = 1'b1;
      end
    end else if (!bank_val_i || !bank_uc_i) begin
      act_o = ACT_LOG_CE;
      if (bank_val_i) new_status_o[ST_OVER] = 1'b1;
    end else begin
      act_o = ACT_MARK_OVF;
    end
  end
endmodule

// File: rtl/mc_bank.sv
module mc_bank import mc_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sw_we_i,
  input  logic [1:0]    sw_sel_i,
  input  logic [DW-1:0] sw_wdata_i,
  input  logic          log_i,
  input  logic [DW-1:0] log_status_i,
  input  logic [DW-1:0] log_addr_i,
  input  logic [DW-1:0] log_misc_i,
  input  logic          mark_ovf_i,
  output logic [DW-1:0] ctl_o,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] misc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o    <= '1;
      status_o <= '0;
      addr_o   <= '0;
      misc_o   <= '0;
    end else begin
      if (sw_we_i) begin
        case (sw_sel_i)
          2'd0: ctl_o    <= sw_wdata_i;
          2'd1: status_o <= sw_wdata_i;
          2'd2: addr_o   <= sw_wdata_i;
          default: misc_o <= sw_wdata_i;
        endcase
      end
      // reports override a same-cycle software write
      if (log_i) begin
        status_o <= log_status_i;
        addr_o   <= log_addr_i;
        misc_o   <= log_misc_i;
      end else if (mark_ovf_i) begin
        status_o[ST_OVER] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mc_logger.sv
module mc_logger import mc_pkg::*; #(
  parameter int NUM_BANKS   = 4,
  parameter bit CTL_PRESENT = 1'b1,
  localparam int AW = $clog2(4 * (NUM_BANKS + 1)),
  localparam int BW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mce_en_i,
  input  logic          inj_valid_i,
  input  logic [7:0]    inj_bank_i,
  input  logic [DW-1:0] inj_status_i,
  input  logic [DW-1:0] inj_gstatus_i,
  input  logic [DW-1:0] inj_addr_i,
  input  logic [DW-1:0] inj_misc_i,
  input  logic          inj_uncond_i,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          reject_o,
  output logic          mce_irq_o,
  output logic          reset_req_o
);
  localparam logic [DW-1:0] CAP_RST = DW'(NUM_BANKS) | (DW'(CTL_PRESENT) << CAP_CTLP);

  logic [DW-1:0] cap_q, gctl_q, gstat_q;
  logic [DW-1:0] ctl_a [NUM_BANKS];
  logic [DW-1:0] st_a  [NUM_BANKS];
  logic [DW-1:0] adr_a [NUM_BANKS];
  logic [DW-1:0] msc_a [NUM_BANKS];
  logic [BW-1:0] bsel;
  logic          bank_ok;
  mc_act_e       act;
  logic [DW-1:0] new_status;

  assign bank_ok = int'(inj_bank_i) < NUM_BANKS;
  assign bsel    = bank_ok ? inj_bank_i[BW-1:0] : '0;

  mc_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .valid_i         (inj_valid_i),
    .bank_i          (inj_bank_i),
    .status_i        (inj_status_i),
    .uncond_i        (inj_uncond_i),
    .os_en_i         (mce_en_i),
    .cap_i           (cap_q),
    .gctl_ones_i     (&gctl_q),
    .mcip_i          (gstat_q[GS_MCIP]),
    .bank_ctl_ones_i (&ctl_a[bsel]),
    .bank_val_i      (st_a[bsel][ST_VAL]),
    .bank_uc_i       (st_a[bsel][ST_UC]),
    .act_o           (act),
    .new_status_o    (new_status)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sw_hit, hit;
    assign sw_hit = reg_we_i && (reg_addr_i[AW-1:2] == (AW-2)'(b + 1));
    assign hit    = bank_ok && (bsel == BW'(b));
    mc_bank u_bank (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .sw_we_i      (sw_hit),
      .sw_sel_i     (reg_addr_i[1:0]),
      .sw_wdata_i   (reg_wdata_i),
      .log_i        (hit && (act == ACT_LOG_UC || act == ACT_LOG_CE)),
      .log_status_i (new_status),
      .log_addr_i   (inj_addr_i),
      .log_misc_i   (inj_misc_i),
      .mark_ovf_i   (hit && act == ACT_MARK_OVF),
      .ctl_o        (ctl_a[b]),
      .status_o     (st_a[b]),
      .addr_o       (adr_a[b]),
      .misc_o       (msc_a[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q       <= CAP_RST;
      gctl_q      <= '1;
      gstat_q     <= '0;
      reject_o    <= 1'b0;
      mce_irq_o   <= 1'b0;
      reset_req_o <= 1'b0;
    end else begin
      if (reg_we_i && reg_addr_i == AW'(0)) cap_q   <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == AW'(1)) gstat_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == AW'(2)) gctl_q  <= reg_wdata_i;
      if (act == ACT_LOG_UC) gstat_q <= inj_gstatus_i;
      reject_o    <= (act == ACT_REJECT);
      mce_irq_o   <= (act == ACT_LOG_UC);
      reset_req_o <= (act == ACT_RESET);
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(0): reg_rdata_o = cap_q;
      AW'(1): reg_rdata_o = gstat_q;
      AW'(2): reg_rdata_o = gctl_q;
      default: ;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (reg_addr_i[AW-1:2] == (AW-2)'(b + 1)) begin
        case (reg_addr_i[1:0])
          2'd0: reg_rdata_o = ctl_a[b];
          2'd1: reg_rdata_o = st_a[b];
          2'd2: reg_rdata_o = adr_a[b];
          default: reg_rdata_o = msc_a[b];
        endcase
      end
    end
  end
endmodule

// File: rtl/mc_logger_chk.sv
module mc_logger_chk import mc_pkg::*; (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          inj_valid_i,
  input logic          st_val,
  input logic          st_uc,
  input logic          mce_en_i,
  input logic [DW-1:0] inj_gstatus_i,
  input logic          reg_we_i,
  input logic [DW-1:0] gstat_q,
  input logic          reject_o,
  input logic          mce_irq_o,
  input logic          reset_req_o
);
  AST_BAD_VALID_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid_i && !st_val |=> reject_o); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reject_o, mce_irq_o, reset_req_o})); // R10
  AST_IRQ_GSTAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mce_irq_o |-> gstat_q == $past(inj_gstatus_i)); // R6
  AST_RESET_NO_LOG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o && !$past(reg_we_i) |-> $stable(gstat_q)); // R5
  AST_OS_OFF_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid_i && !mce_en_i |=> !mce_irq_o); // R5
  AST_CE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_valid_i && !st_uc |=> !mce_irq_o); // R7
endmodule

bind mc_logger mc_logger_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .inj_valid_i   (inj_valid_i),
  .st_val        (inj_status_i[63]),
  .st_uc         (inj_status_i[61]),
  .mce_en_i      (mce_en_i),
  .inj_gstatus_i (inj_gstatus_i),
  .reg_we_i      (reg_we_i),
  .gstat_q       (gstat_q),
  .reject_o      (reject_o),
  .mce_irq_o     (mce_irq_o),
  .reset_req_o   (reset_req_o)
);

// File: tb/mc_logger_bench.sv
`timescale 1ns/1ps
module mc_logger_bench;
  localparam int NB = 4;
  localparam int AW = 5;
  localparam logic [63:0] VAL = 64'h1 << 63;
  localparam logic [63:0] OVR = 64'h1 << 62;
  localparam logic [63:0] UC  = 64'h1 << 61;
  localparam logic [63:0] AR  = 64'h1 << 55;
  localparam logic [63:0] ONES = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mce_en = 1'b1, inj_valid = 1'b0, inj_uncond = 1'b0, reg_we = 1'b0;
  logic [7:0] inj_bank = '0;
  logic [63:0] inj_status = '0, inj_gstatus = '0, inj_addr = '0, inj_misc = '0;
  logic [AW-1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic reject, irq, rreq;
  logic o_rej, o_irq, o_rst;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  mc_logger #(.NUM_BANKS(NB), .CTL_PRESENT(1'b1)) u_mc_logger (
    .clk_i(clk), .rst_ni(rst_n), .mce_en_i(mce_en), .inj_valid_i(inj_valid),
    .inj_bank_i(inj_bank), .inj_status_i(inj_status), .inj_gstatus_i(inj_gstatus),
    .inj_addr_i(inj_addr), .inj_misc_i(inj_misc), .inj_uncond_i(inj_uncond),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .reject_o(reject), .mce_irq_o(irq), .reset_req_o(rreq));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [63:0] d);
    @(negedge clk); reg_addr = AW'(a); #1 d = reg_rdata;
  endtask

  task automatic wr(int a, logic [63:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk); #1 reg_we = 1'b0;
  endtask

  task automatic rd_chk(string req, int a, logic [63:0] exp);
    logic [63:0] d;
    rd(a, d); chk(req, d, exp);
  endtask

  task automatic inject(int b, logic [63:0] st, logic [63:0] gs, logic [63:0] ad,
                        logic [63:0] ms, logic unc);
    @(negedge clk);
    inj_valid = 1'b1; inj_bank = 8'(b); inj_status = st; inj_gstatus = gs;
    inj_addr = ad; inj_misc = ms; inj_uncond = unc;
    @(posedge clk); #1;
    inj_valid = 1'b0; inj_uncond = 1'b0;
    o_rej = reject; o_irq = irq; o_rst = rreq;
  endtask

  task automatic outs(string req, logic r, logic i, logic s);
    chk(req, {61'b0, o_rej, o_irq, o_rst}, {61'b0, r, i, s});
  endtask

  task automatic t_reset;
    rd_chk("R1 cap", 0, 64'h104);
    rd_chk("R1 gstat", 1, 64'h0);
    rd_chk("R1 gctl", 2, ONES);
    for (int b = 0; b < NB; b++) begin
      rd_chk("R1 bank ctl", 4 + 4 * b, ONES);
      rd_chk("R1 bank status", 5 + 4 * b, 64'h0);
    end
    chk("R10 idle outputs", {61'b0, reject, irq, rreq}, 64'h0);
  endtask

  task automatic t_regport;
    wr(15, 64'h1234);
    rd_chk("R9 bank2 misc", 15, 64'h1234);
    wr(15, 64'h0);
    wr(3, 64'hdead);
    rd_chk("R9 unmapped", 3, 64'h0);
  endtask

  task automatic t_ce;
    inject(0, VAL | 64'hAA, 0, 64'hA1, 64'hB1, 0);
    outs("R7 first ce", 0, 0, 0);
    rd_chk("R7 ce status", 5, VAL | 64'hAA);
    rd_chk("R7 ce misc", 7, 64'hB1);
    inject(0, VAL | 64'hBB, 0, 64'hA2, 64'hB2, 0);
    rd_chk("R7 ce overwrite ovf", 5, VAL | OVR | 64'hBB);
    rd_chk("R7 ce addr", 6, 64'hA2);
  endtask

  task automatic t_uc;
    inject(1, VAL | UC | AR | 64'h11, 64'h5, 64'hC1, 64'hC2, 0);
    outs("R6 uc irq", 0, 1, 0);
    @(posedge clk); #1;
    chk("R10 irq one cycle", {63'b0, irq}, 64'h0);
    rd_chk("R6 uc status", 9, VAL | UC | AR | 64'h11);
    rd_chk("R6 uc addr", 10, 64'hC1);
    rd_chk("R6 gstat", 1, 64'h5);
    wr(1, 0);
    inject(1, VAL | 64'h22, 0, 64'hD1, 64'hD2, 0);
    outs("R8 ce on uc", 0, 0, 0);
    rd_chk("R8 ovf only", 9, VAL | UC | AR | OVR | 64'h11);
    rd_chk("R8 addr kept", 10, 64'hC1);
  endtask

  task automatic t_escalate;
    mce_en = 1'b0;
    inject(2, VAL | UC | AR | 64'h33, 64'h4, 64'hE1, 0, 0);
    outs("R5 os disabled reset", 0, 0, 1);
    rd_chk("R5 no log", 13, 64'h0);
    mce_en = 1'b1;
    inject(2, VAL | UC | AR | 64'h33, 64'h4, 64'hE1, 0, 0);
    outs("R6 uc log b2", 0, 1, 0);
    inject(3, VAL | UC | AR | 64'h44, 64'h5, 0, 0, 0);
    outs("R5 nested reset", 0, 0, 1);
    rd_chk("R5 b3 untouched", 17, 64'h0);
    rd_chk("R5 gstat kept", 1, 64'h4);
    inject(3, VAL | UC | 64'h45, 64'h5, 0, 0, 0);
    outs("R3 uc non-ar dropped", 0, 0, 0);
    inject(3, VAL | 64'h46, 0, 0, 0, 0);
    outs("R3 ce dropped", 0, 0, 0);
    rd_chk("R3 b3 empty", 17, 64'h0);
    inject(3, VAL | 64'h47, 0, 64'hF1, 0, 1);
    rd_chk("R3 uncond logs", 17, VAL | 64'h47);
    wr(1, 0);
    inject(2, VAL | UC | AR | 64'h55, 64'h4, 64'hE2, 0, 0);
    outs("R6 uc over valid", 0, 1, 0);
    rd_chk("R6 uc ovf", 13, VAL | UC | AR | OVR | 64'h55);
    wr(1, 0);
  endtask

  task automatic t_masks;
    wr(2, 0);
    inject(3, VAL | UC | AR | 64'h66, 64'h1, 0, 0, 0);
    outs("R4 gctl drop", 0, 0, 0);
    rd_chk("R4 gctl b3 kept", 17, VAL | 64'h47);
    wr(2, ONES);
    wr(16, 0);
    inject(3, VAL | UC | AR | 64'h66, 64'h1, 0, 0, 0);
    outs("R4 bank ctl drop", 0, 0, 0);
    rd_chk("R4 bank ctl b3 kept", 17, VAL | 64'h47);
    wr(16, ONES);
    wr(0, 64'h004);
    wr(2, 0);
    inject(3, VAL | UC | AR | 64'h66, 64'h1, 0, 0, 0);
    outs("R4 no ctl present logs", 0, 1, 0);
    rd_chk("R4 b3 logged", 17, VAL | UC | AR | OVR | 64'h66);
    wr(0, 64'h104);
    wr(2, ONES);
    wr(1, 0);
  endtask

  task automatic t_reject;
    wr(0, 0);
    inject(0, VAL | 64'h77, 0, 0, 0, 0);
    outs("R2 cap zero", 1, 0, 0);
    wr(0, 64'h104);
    inject(4, VAL | 64'h77, 0, 0, 0, 0);
    outs("R2 bank beyond", 1, 0, 0);
    wr(0, 64'h102);
    inject(2, VAL | UC | AR | 64'h77, 0, 0, 0, 0);
    outs("R2 bank beyond cap", 1, 0, 0);
    rd_chk("R2 b2 kept", 13, VAL | UC | AR | OVR | 64'h55);
    wr(0, 64'h104);
    inject(0, 64'h77, 0, 0, 0, 0);
    outs("R2 valid clear", 1, 0, 0);
    rd_chk("R2 b0 kept", 5, VAL | OVR | 64'hBB);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_regport();
    t_ce();
    t_uc();
    t_escalate();
    t_masks();
    t_reject();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule